// File: doc/BRIEF.md
# Pixel-Chain Serial Frame Transmitter

This block drives a daisy chain of pixel nodes over two wires: a serial data line and a serial clock line. A transfer starts with a one-cycle start pulse and a run-time pixel count. The block first emits a header of zero bits. It then takes the pixels one at a time through a valid/ready handshake and sends each as a marker bit followed by three 5-bit colour fields. After the last pixel it sends one zero-data clock pulse for each pixel in the chain, so that every node can pass the frame on to its neighbour.

The serial clock comes from the system clock through a programmable half-period divider. The divider value is latched at the start of each transfer and clamped from below. Data changes only on the system edge where the serial clock falls, so each node, which samples on the rising edge, sees at least one full half-period of setup and of hold. Busy covers the whole transfer. Done pulses for one cycle after the last clock pulse completes.

Top module: `pixel_chain_tx`

## Requirements
- R1: Every transfer begins with exactly 32 serial clock pulses with data 0 at each rising edge.
- R2: Each pixel is sent as 16 bits, MSB first: a 1, then red `pix_data_i[14:10]`, green `pix_data_i[9:5]`, blue `pix_data_i[4:0]`, each colour MSB first.
- R3: After the last pixel, exactly as many pulses as the pixel count are sent, with data 0 at each rising edge.
- R4: A transfer with a pixel count of 0 sends the 32 header pulses and nothing else.
- R5: `sdata_o` never changes while `sclk_o` is high, and never on the edge where `sclk_o` rises.
- R6: The high phase of `sclk_o` lasts exactly H system cycles and the low phase lasts at least H, where H is `half_period_i` latched at start, raised to MIN_HALF (default 2) if smaller.
- R7: A pixel is taken on a cycle with `pix_valid_i` and `pix_ready_o` both high. `pix_ready_o` is high only while busy. `sclk_o` stays low while the block waits for a pixel. Exactly the pixel count of pixels is taken per transfer.
- R8: A start pulse while busy is ignored. The running transfer's stream, length and done pulse are unchanged.
- R9: `busy_o` rises one cycle after an accepted start. `done_o` is a single-cycle pulse, issued after the final rising edge with `busy_o` already low.
- R10: While `rst_ni` is low, `sclk_o`, `sdata_o`, `busy_o`, `done_o` and `pix_ready_o` are all 0, including when reset interrupts a transfer.
- R11: While not busy, `sclk_o` and `sdata_o` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| pix_count_i | input | CNT_W | Number of pixels in the chain |
| half_period_i | input | DIV_W | Serial clock half-period in system cycles |
| pix_valid_i | input | 1 | Pixel word available |
| pix_data_i | input | 15 | Pixel colours {red, green, blue}, 5 bits each |
| pix_ready_o | output | 1 | Block will take a pixel this cycle if valid |
| sclk_o | output | 1 | Serial clock to the chain |
| sdata_o | output | 1 | Serial data to the chain |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at end of transfer |

## Verification
The bound checker watches every cycle for the line relations that must always hold. Data stays steady through the high phase and the rising edge. Both lines stay quiet while idle. Done is a single pulse at the busy-to-idle step, ready never appears outside a transfer, and busy follows an idle start. The frame content cannot be seen in any single cycle: header length, marker bit, colour order, tail count, exact phase lengths, the clamp of the divider and the ignored restart all depend on a whole transfer. The bench shows these by capturing every bit at each rising edge and comparing the stream with one built from the requirements, under stalled and unstalled pixel sources.

// File: rtl/pct_pkg.sv
package pct_pkg;
  localparam int unsigned HDR_BITS = 32;
  localparam int unsigned COLOR_W  = 5;
  localparam int unsigned PIX_W    = 3 * COLOR_W;
  localparam int unsigned WORD_W   = PIX_W + 1;
  localparam int unsigned BIT_CW   = $clog2(HDR_BITS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_FETCH,
    ST_PIX,
    ST_TAIL,
    ST_DRAIN
  } seq_state_e;

  typedef struct packed {
    logic [COLOR_W-1:0] red;
    logic [COLOR_W-1:0] green;
    logic [COLOR_W-1:0] blue;
  } rgb_t;
endpackage

// File: rtl/pct_bit_timer.sv
module pct_bit_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sclk_o,
  output logic             ready_o
);
  logic             run_q, hi_q;
  logic [DIV_W-1:0] cnt_q;
  logic             last_c, bit_end_c;

  assign last_c    = (cnt_q == half_i - DIV_W'(1));
  assign bit_end_c = run_q & hi_q & last_c;
  assign ready_o   = ~run_q | bit_end_c;
  assign sclk_o    = hi_q;

  // low phase first, then high phase, each half_i cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      hi_q  <= 1'b0;
      cnt_q <= '0;
    end else if (launch_i) begin
      run_q <= 1'b1;
      hi_q  <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      if (last_c) begin
        cnt_q <= '0;
        if (hi_q) begin
          run_q <= 1'b0;
          hi_q  <= 1'b0;
        end else begin
          hi_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/pct_shift.sv
module pct_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  assign msb_o = sr_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= word_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/pct_seq.sv
module pct_seq
  import pct_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned MIN_HALF = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [DIV_W-1:0] half_i,
  input  logic             pix_valid_i,
  input  logic             timer_ready_i,
  output logic             launch_o,
  output logic             sel_pix_o,
  output logic             load_o,
  output logic             pix_ready_o,
  output logic [DIV_W-1:0] half_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [DIV_W-1:0]  HALF_FLOOR = DIV_W'(MIN_HALF);
  localparam logic [BIT_CW-1:0] HDR_LAST   = BIT_CW'(HDR_BITS - 1);
  localparam logic [BIT_CW-1:0] PIX_LAST   = BIT_CW'(WORD_W - 1);

  seq_state_e        state_q;
  logic [BIT_CW-1:0] bit_q;
  logic [CNT_W-1:0]  rem_q, count_q;
  logic [DIV_W-1:0]  half_q;
  logic              done_q;
  logic              shifting_c;

  assign shifting_c  = (state_q == ST_HDR) || (state_q == ST_PIX) || (state_q == ST_TAIL);
  assign launch_o    = shifting_c & timer_ready_i;
  assign sel_pix_o   = (state_q == ST_PIX);
  assign pix_ready_o = (state_q == ST_FETCH);
  assign load_o      = pix_ready_o & pix_valid_i;
  assign half_o      = half_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      rem_q   <= '0;
      count_q <= '0;
      half_q  <= HALF_FLOOR;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_HDR;
          bit_q   <= HDR_LAST;
          count_q <= count_i;
          half_q  <= (half_i < HALF_FLOOR) ? HALF_FLOOR : half_i;
        end
        ST_HDR: if (launch_o) begin
          if (bit_q == '0) begin
            rem_q   <= count_q;
            state_q <= (count_q == '0) ? ST_DRAIN : ST_FETCH;
          end else begin
            bit_q <= bit_q - BIT_CW'(1);
          end
        end
        ST_FETCH: if (load_o) begin
          state_q <= ST_PIX;
          bit_q   <= PIX_LAST;
        end
        ST_PIX: if (launch_o) begin
          if (bit_q == '0) begin
            if (rem_q == CNT_W'(1)) begin
              rem_q   <= count_q;
              state_q <= ST_TAIL;
            end else begin
              rem_q   <= rem_q - CNT_W'(1);
              state_q <= ST_FETCH;
            end
          end else begin
            bit_q <= bit_q - BIT_CW'(1);
          end
        end
        ST_TAIL: if (launch_o) begin
          if (rem_q == CNT_W'(1)) state_q <= ST_DRAIN;
          else                    rem_q   <= rem_q - CNT_W'(1);
        end
        ST_DRAIN: if (timer_ready_i) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pixel_chain_tx.sv
module pixel_chain_tx
  import pct_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned MIN_HALF = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] pix_count_i,
  input  logic [DIV_W-1:0] half_period_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_data_i,
  output logic             pix_ready_o,
  output logic             sclk_o,
  output logic             sdata_o,
  output logic             busy_o,
  output logic             done_o
);
  logic              launch, sel_pix, load, timer_ready, msb;
  logic [DIV_W-1:0]  half_eff;
  logic [WORD_W-1:0] word;
  rgb_t              pix;
  logic              sdata_q;

  assign pix     = rgb_t'(pix_data_i);
  assign word    = {1'b1, pix.red, pix.green, pix.blue};
  assign sdata_o = sdata_q;

  pct_seq #(
    .CNT_W   (CNT_W),
    .DIV_W   (DIV_W),
    .MIN_HALF(MIN_HALF)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .count_i      (pix_count_i),
    .half_i       (half_period_i),
    .pix_valid_i  (pix_valid_i),
    .timer_ready_i(timer_ready),
    .launch_o     (launch),
    .sel_pix_o    (sel_pix),
    .load_o       (load),
    .pix_ready_o  (pix_ready_o),
    .half_o       (half_eff),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  pct_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .half_i  (half_eff),
    .sclk_o  (sclk_o),
    .ready_o (timer_ready)
  );

  pct_shift #(.W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .word_i (word),
    .shift_i(launch & sel_pix),
    .msb_o  (msb)
  );

  // data moves only on the edge that starts a low phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sdata_q <= 1'b0;
    else if (launch) sdata_q <= sel_pix & msb;
  end
endmodule

// File: rtl/pixel_chain_tx_chk.sv
module pixel_chain_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic sclk_o,
  input logic sdata_o,
  input logic pix_ready_o
);
  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o)); // R5
  AST_SETUP_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(sdata_o)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sclk_o && !sdata_o)); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R9
  AST_START_TO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R9
  AST_READY_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_ready_o |-> busy_o); // R7
endmodule

bind pixel_chain_tx pixel_chain_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .sclk_o     (sclk_o),
  .sdata_o    (sdata_o),
  .pix_ready_o(pix_ready_o)
);

// File: tb/pixel_chain_tx_tb_top.sv
module pixel_chain_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int DIV_W      = 8;
  localparam int MIN_HALF   = 2;
  localparam int MAXB       = 1024;
  localparam int NVEC       = 6;
  // {count, half_period, valid gap}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd1, 8'd2, 8'd0},
    {8'd3, 8'd1, 8'd0},
    {8'd4, 8'd3, 8'd2},
    {8'd6, 8'd2, 8'd1},
    {8'd2, 8'd0, 8'd0},
    {8'd5, 8'd4, 8'd3}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] pix_count = '0;
  logic [DIV_W-1:0] half_period = '0;
  logic             pix_valid = 1'b0;
  logic [14:0]      pix_data = '0;
  logic             pix_ready, sclk, sdata, busy, done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_chain_tx #(.CNT_W(CNT_W), .DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pix_count_i(pix_count),
    .half_period_i(half_period), .pix_valid_i(pix_valid), .pix_data_i(pix_data),
    .pix_ready_o(pix_ready), .sclk_o(sclk), .sdata_o(sdata),
    .busy_o(busy), .done_o(done)
  );

  function automatic logic [14:0] pix_val(int seed, int i);
    return 15'((seed * 7919 + i * 1237 + i * i * 613) & 32'h7fff);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // pixel source
  int   pix_idx = 0;
  logic idx_clr = 1'b0;
  int   seed_v = 1;
  int   gap_v = 0;
  int   cyc = 0;
  always @(posedge clk) begin
    if (idx_clr) pix_idx <= 0;
    else if (pix_valid && pix_ready) pix_idx <= pix_idx + 1;
  end
  always @(negedge clk) begin
    cyc++;
    pix_data  = pix_val(seed_v, pix_idx);
    pix_valid = (gap_v == 0) ? 1'b1 : ((cyc % (gap_v + 1)) != 0);
  end

  // line monitor
  logic cap [MAXB];
  int   cap_n = 0, hi_run = 0, lo_run = 0, v5 = 0, v6 = 0, v11 = 0;
  int   done_n = 0, cap_at_done = 0, he = MIN_HALF;
  logic busy_at_done = 1'b0;
  logic p_sclk = 1'b0, p_sdata = 1'b0, p_busy = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !p_busy) begin
        cap_n = 0; v5 = 0; v6 = 0; done_n = 0; lo_run = 0; hi_run = 0;
      end
      if (sclk && !p_sclk) begin
        if (cap_n < MAXB) cap[cap_n] = sdata;
        cap_n++;
        if (sdata !== p_sdata) v5++;
        if (lo_run < he) v6++;
        hi_run = 1;
      end else if (sclk) begin
        hi_run++;
        if (sdata !== p_sdata) v5++;
      end
      if (!sclk && p_sclk) begin
        if (hi_run != he) v6++;
        lo_run = 1;
      end else if (!sclk) lo_run++;
      if (!busy && (sclk || sdata)) v11++;
      if (done) begin
        done_n++; cap_at_done = cap_n; busy_at_done = busy;
      end
    end
    p_sclk = sclk; p_sdata = sdata; p_busy = busy;
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
      finish_run();
    end
  end

  task automatic run_xfer(int cnt, int half, int gap, int seed, bit inject);
    logic exp [MAXB];
    int n = 0, t = 0, bad1 = 0, bad2 = 0, bad3 = 0, lim;
    @(negedge clk);
    seed_v = seed; gap_v = gap; he = (half < MIN_HALF) ? MIN_HALF : half;
    idx_clr = 1'b1; pix_count = CNT_W'(cnt); half_period = DIV_W'(half); start = 1'b1;
    @(negedge clk);
    start = 1'b0; idx_clr = 1'b0;
    check(busy === 1'b1, "R9", "busy one cycle after start", int'(busy), 1);
    if (inject) begin
      repeat (40) @(negedge clk);
      pix_count = CNT_W'(cnt + 3); half_period = DIV_W'(1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    repeat (2) @(negedge clk);
    while (done_n == 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    for (int i = 0; i < 32; i++) exp[n++] = 1'b0;
    for (int p = 0; p < cnt; p++) begin
      logic [14:0] w = pix_val(seed, p);
      exp[n++] = 1'b1;
      for (int b = 14; b >= 0; b--) exp[n++] = w[b];
    end
    for (int i = 0; i < cnt; i++) exp[n++] = 1'b0;
    lim = (cap_n < n) ? cap_n : n;
    for (int i = 0; i < lim; i++) begin
      if (cap[i] !== exp[i]) begin
        if (i < 32) bad1++;
        else if (i < 32 + 16 * cnt) bad2++;
        else bad3++;
      end
    end
    check(cap_n == n, (cnt == 0) ? "R4" : "R3", "pulse count", cap_n, n);
    check(bad1 == 0, "R1", "header bit mismatches", bad1, 0);
    check(bad2 == 0, "R2", "pixel bit mismatches", bad2, 0);
    check(bad3 == 0, "R3", "tail bit mismatches", bad3, 0);
    check(v5 == 0, "R5", "data moved at rise or while high", v5, 0);
    check(v6 == 0, "R6", "phase length violations", v6, 0);
    check(pix_idx == cnt, "R7", "pixels taken", pix_idx, cnt);
    check(done_n == 1, "R9", "done pulses", done_n, 1);
    check(cap_at_done == n && !busy_at_done, "R9", "pulses before done", cap_at_done, n);
    if (inject) check(done_n == 1 && cap_n == n, "R8", "restart while busy changed stream", cap_n, n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({sclk, sdata, busy, done, pix_ready} == 5'b0, "R10", "outputs in reset",
          int'({sclk, sdata, busy, done, pix_ready}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int v = 0; v < NVEC; v++)
      run_xfer(int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]), v + 1, 1'b0);
    // R4: empty chain
    run_xfer(0, 3, 0, 9, 1'b0);
    // R8: second start during a transfer
    run_xfer(3, 2, 1, 11, 1'b1);
    // R10: reset in the middle of a transfer
    @(negedge clk);
    pix_count = 8'd4; half_period = 8'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (70) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check({sclk, sdata, busy, done, pix_ready} == 5'b0, "R10", "outputs after mid reset",
          int'({sclk, sdata, busy, done, pix_ready}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(busy == 1'b0 && sclk == 1'b0, "R10", "idle after mid reset", int'(busy), 0);
    run_xfer(2, 2, 0, 13, 1'b0);
    check(v11 == 0, "R11", "line activity while idle", v11, 0);
    finish_run();
  end
endmodule